// File: doc/BRIEF.md
# Analog Window Watchdog Monitor

This block sits beside an analog-to-digital conversion engine and watches every result it produces. Each result arrives with a valid strobe, a 12-bit unsigned value and a 5-bit channel tag. When a result on the one guarded channel lies outside a programmed window, the block sets an event flag. The window is inclusive. The flag stays set until software clears it.

Software writes the configuration through simple write-enable ports: a low bound, a high bound, the guarded-channel code and an interrupt enable. Each bound is written as a 16-bit word, and only its low 12 bits are kept. A registered interrupt line follows the flag while the enable is set. The block contains no bus logic. A host register file drives these ports directly.

Top module: `awd_monitor`

## Requirements
- R1: A valid result on the guarded channel whose value is strictly below the low bound sets `flag_o` at the clock edge that samples it.
- R2: A valid result on the guarded channel whose value is strictly above the high bound sets `flag_o` at the clock edge that samples it.
- R3: A result equal to the low bound or to the high bound is inside the window and does not set the flag.
- R4: A bound write keeps bits [11:0] of its 16-bit write word, and bits [15:12] have no effect. A bound written at one edge applies to results sampled from the next edge on.
- R5: The guarded-channel select is 5 bits wide and accepts codes 0 to 17. A write of a code from 18 to 31 is dropped, and the previous selection remains in force.
- R6: Results tagged with any channel other than the guarded one never change the flag.
- R7: Once set, the flag stays set until `clr_i` is sampled high. The flag is then 0 after that edge.
- R8: When a set condition and `clr_i` are sampled at the same edge, the flag ends up set.
- R9: `irq_o` is the registered AND of the flag and the interrupt enable. It therefore rises one cycle after the flag rises, and it falls one cycle after a clear.
- R10: Bound comparisons are unsigned. For example, 0xFFF counts as above a high bound of 0x800.
- R11: After reset, `flag_o` and `irq_o` are 0, the low bound is 0, the high bound is 0xFFF, channel 0 is guarded and the interrupt is disabled. With these values, no result sets the flag.
- R12: While `conv_valid_i` is low, the result inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_valid_i | input | 1 | Result valid strobe |
| conv_data_i | input | 12 | Converted value, unsigned |
| conv_chan_i | input | 5 | Channel tag of the result |
| lo_we_i | input | 1 | Low bound write enable |
| lo_wdata_i | input | 16 | Low bound write word |
| hi_we_i | input | 1 | High bound write enable |
| hi_wdata_i | input | 16 | High bound write word |
| sel_we_i | input | 1 | Guarded channel write enable |
| sel_wdata_i | input | 5 | Guarded channel code |
| ien_we_i | input | 1 | Interrupt enable write strobe |
| ien_wdata_i | input | 1 | Interrupt enable value |
| clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky out-of-window event flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets several corner cases:

- **Exact bounds.** It drives results equal to each bound. A design that used strict comparisons the wrong way round would raise false events at these points.
- **Upper write bits.** The bound words are written with their upper four bits set. A design that kept those bits would flag a low-range value as below the bound.
- **Illegal channel codes.** It writes an illegal channel code and expects the earlier selection to remain guarded. A design that stored the code would guard no channel at all.
- **Set and clear together.** It sends a clear in the same cycle as an out-of-window result. A design that let the clear win would lose the event.
- **Interrupt timing.** It checks the interrupt one cycle after each flag change. A design with a combinational interrupt, or a missing enable gate, shows up as a mismatch in that cycle.
- **Unsigned comparison.** It uses 0x7FF and 0xFFF as test values. A signed comparison would treat 0xFFF as negative and misjudge it against the bounds.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int DATA_W   = 12;
  localparam int REG_W    = 16;
  localparam int CHAN_W   = 5;
  localparam int NUM_CHAN = 18;

  typedef enum int {
    THR_LO = 0,
    THR_HI = 1
  } thr_idx_e;

  localparam int NUM_THR = 2;
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
  import awd_pkg::*;
#(
  parameter int DATA_W   = awd_pkg::DATA_W,
  parameter int REG_W    = awd_pkg::REG_W,
  parameter int CHAN_W   = awd_pkg::CHAN_W,
  parameter int NUM_CHAN = awd_pkg::NUM_CHAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic [REG_W-1:0]  lo_wdata_i,
  input  logic              hi_we_i,
  input  logic [REG_W-1:0]  hi_wdata_i,
  input  logic              sel_we_i,
  input  logic [CHAN_W-1:0] sel_wdata_i,
  input  logic              ien_we_i,
  input  logic              ien_wdata_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [CHAN_W-1:0] sel_o,
  output logic              ien_o
);
  localparam logic [CHAN_W-1:0] SEL_MAX = CHAN_W'(NUM_CHAN - 1);

  logic [NUM_THR-1:0] thr_we;
  logic [REG_W-1:0]   thr_wdata [NUM_THR];
  logic [DATA_W-1:0]  thr_q     [NUM_THR];

  assign thr_we[THR_LO]    = lo_we_i;
  assign thr_we[THR_HI]    = hi_we_i;
  assign thr_wdata[THR_LO] = lo_wdata_i;
  assign thr_wdata[THR_HI] = hi_wdata_i;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    // low bound resets to zero, high bound to full scale: window initially open
    localparam logic [DATA_W-1:0] RST_VAL = (g == int'(THR_HI)) ? '1 : '0;
    logic [REG_W-DATA_W-1:0] unused_upper;
    assign unused_upper = thr_wdata[g][REG_W-1:DATA_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         thr_q[g] <= RST_VAL;
      else if (thr_we[g])  thr_q[g] <= thr_wdata[g][DATA_W-1:0];
    end
  end

  assign lo_o = thr_q[THR_LO];
  assign hi_o = thr_q[THR_HI];

  // out-of-range channel codes are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               sel_o <= '0;
    else if (sel_we_i && sel_wdata_i <= SEL_MAX) sel_o <= sel_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_o <= 1'b0;
    else if (ien_we_i) ien_o <= ien_wdata_i;
  end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
  parameter int DATA_W = awd_pkg::DATA_W,
  parameter int CHAN_W = awd_pkg::CHAN_W
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [CHAN_W-1:0] sel_i,
  output logic              hit_o
);
  logic guarded, below, above;

  assign guarded = valid_i && (chan_i == sel_i);
  // unsigned, bounds inclusive
  assign below   = data_i < lo_i;
  assign above   = data_i > hi_i;
  assign hit_o   = guarded && (below || above);
endmodule

// File: rtl/awd_event_flag.sv
module awd_event_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= flag_o & ien_i;
  end
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor #(
  parameter int DATA_W   = awd_pkg::DATA_W,
  parameter int REG_W    = awd_pkg::REG_W,
  parameter int CHAN_W   = awd_pkg::CHAN_W,
  parameter int NUM_CHAN = awd_pkg::NUM_CHAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [CHAN_W-1:0] conv_chan_i,
  input  logic              lo_we_i,
  input  logic [REG_W-1:0]  lo_wdata_i,
  input  logic              hi_we_i,
  input  logic [REG_W-1:0]  hi_wdata_i,
  input  logic              sel_we_i,
  input  logic [CHAN_W-1:0] sel_wdata_i,
  input  logic              ien_we_i,
  input  logic              ien_wdata_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [CHAN_W-1:0] sel_q;
  logic              ien_q;
  logic              hit;

  awd_cfg_regs #(
    .DATA_W(DATA_W), .REG_W(REG_W), .CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)
  ) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_we_i     (lo_we_i),
    .lo_wdata_i  (lo_wdata_i),
    .hi_we_i     (hi_we_i),
    .hi_wdata_i  (hi_wdata_i),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .ien_we_i    (ien_we_i),
    .ien_wdata_i (ien_wdata_i),
    .lo_o        (lo_q),
    .hi_o        (hi_q),
    .sel_o       (sel_q),
    .ien_o       (ien_q)
  );

  awd_window_cmp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) i_cmp (
    .valid_i (conv_valid_i),
    .data_i  (conv_data_i),
    .chan_i  (conv_chan_i),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .sel_i   (sel_q),
    .hit_o   (hit)
  );

  awd_event_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_i),
    .ien_i  (ien_q),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/awd_monitor_chk.sv
module awd_monitor_chk #(
  parameter int DATA_W   = awd_pkg::DATA_W,
  parameter int CHAN_W   = awd_pkg::CHAN_W,
  parameter int NUM_CHAN = awd_pkg::NUM_CHAN
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_valid_i,
  input logic [DATA_W-1:0] conv_data_i,
  input logic [CHAN_W-1:0] conv_chan_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] lo_q,
  input logic [DATA_W-1:0] hi_q,
  input logic [CHAN_W-1:0] sel_q,
  input logic              ien_q,
  input logic              flag_o,
  input logic              irq_o
);
  logic on_sel;
  assign on_sel = conv_valid_i && (conv_chan_i == sel_q);

  assert_below_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_sel && conv_data_i < lo_q) |=> flag_o);

  assert_above_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_sel && conv_data_i > hi_q) |=> flag_o);

  assert_bound_inside_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !clr_i && on_sel && lo_q <= hi_q &&
     (conv_data_i == lo_q || conv_data_i == hi_q)) |=> !flag_o);

  assert_sel_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q <= CHAN_W'(NUM_CHAN - 1));

  assert_other_chan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !on_sel) |=> !flag_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !on_sel) |=> !flag_o);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && on_sel && conv_data_i > hi_q) |=> flag_o);

  assert_irq_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && ien_q) |=> irq_o);

  assert_irq_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_o && ien_q) |=> !irq_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R11: assert (!flag_o && !irq_o);
    end
  end
endmodule

bind awd_monitor awd_monitor_chk #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)
) i_awd_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_valid_i (conv_valid_i),
  .conv_data_i  (conv_data_i),
  .conv_chan_i  (conv_chan_i),
  .clr_i        (clr_i),
  .lo_q         (lo_q),
  .hi_q         (hi_q),
  .sel_q        (sel_q),
  .ien_q        (ien_q),
  .flag_o       (flag_o),
  .irq_o        (irq_o)
);

// File: tb/test_awd_monitor.sv
module test_awd_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic [4:0]  chan = '0;
  logic        lo_we = 1'b0, hi_we = 1'b0, sel_we = 1'b0, ien_we = 1'b0, ien_wd = 1'b0;
  logic [15:0] lo_wd = '0, hi_wd = '0;
  logic [4:0]  sel_wd = '0;
  logic        clr = 1'b0;
  logic        flag, irq;

  always #5 clk = ~clk;

  awd_monitor i_awd_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .conv_valid_i(valid), .conv_data_i(data), .conv_chan_i(chan),
    .lo_we_i(lo_we), .lo_wdata_i(lo_wd), .hi_we_i(hi_we), .hi_wdata_i(hi_wd),
    .sel_we_i(sel_we), .sel_wdata_i(sel_wd), .ien_we_i(ien_we), .ien_wdata_i(ien_wd),
    .clr_i(clr), .flag_o(flag), .irq_o(irq)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each rising edge
  int m_lo, m_hi, m_sel, m_en, m_flag, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 4095; m_sel = 0; m_en = 0; m_flag = 0; m_irq = 0;
    end else begin
      int d, hitv, nflag;
      d     = int'(data);
      hitv  = (valid && int'(chan) == m_sel && (d < m_lo || d > m_hi)) ? 1 : 0;
      nflag = hitv ? 1 : (clr ? 0 : m_flag);
      m_irq = (m_flag && m_en) ? 1 : 0;
      m_flag = nflag;
      if (lo_we)  m_lo = int'(lo_wd) % 4096;
      if (hi_we)  m_hi = int'(hi_wd) % 4096;
      if (sel_we && int'(sel_wd) < 18) m_sel = int'(sel_wd);
      if (ien_we) m_en = ien_wd ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(flag) == m_flag, "R7 per-cycle flag vs model", int'(flag), m_flag);
      check(int'(irq) == m_irq, "R9 per-cycle irq vs model", int'(irq), m_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic conv(input int c, input int v);
    valid = 1'b1; chan = 5'(c); data = 12'(v);
    tick();
    valid = 1'b0;
  endtask

  task automatic wr_lo(input int v);
    lo_we = 1'b1; lo_wd = 16'(v); tick(); lo_we = 1'b0;
  endtask

  task automatic wr_hi(input int v);
    hi_we = 1'b1; hi_wd = 16'(v); tick(); hi_we = 1'b0;
  endtask

  task automatic wr_sel(input int v);
    sel_we = 1'b1; sel_wd = 5'(v); tick(); sel_we = 1'b0;
  endtask

  task automatic wr_ien(input bit v);
    ien_we = 1'b1; ien_wd = v; tick(); ien_we = 1'b0;
  endtask

  task automatic clear();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check(flag == 1'b0, "R11 flag in reset", int'(flag), 0);
    check(irq == 1'b0, "R11 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    tick();

    // R11: default window admits full scale
    conv(0, 0);
    check(flag == 1'b0, "R11 default lo, value 0", int'(flag), 0);
    conv(0, 4095);
    check(flag == 1'b0, "R11 default hi, value 4095", int'(flag), 0);

    // R4: upper bits of bound words set, must be dropped
    wr_lo('hF100);
    wr_hi('hA800);
    wr_ien(1'b1);
    conv(0, 'h100);
    check(flag == 1'b0, "R4 upper bits ignored / R3 equal lo", int'(flag), 0);
    conv(0, 'h800);
    check(flag == 1'b0, "R3 equal hi inside", int'(flag), 0);

    conv(5, 'h050);
    check(flag == 1'b0, "R6 other channel below lo", int'(flag), 0);
    valid = 1'b0; chan = '0; data = '0;
    tick();
    check(flag == 1'b0, "R12 valid low ignored", int'(flag), 0);

    conv(0, 'h0FF);
    check(flag == 1'b1, "R1 below lo sets flag", int'(flag), 1);
    check(irq == 1'b0, "R9 irq lags flag", int'(irq), 0);
    tick();
    check(irq == 1'b1, "R9 irq after one cycle", int'(irq), 1);
    conv(3, 'h000);
    check(flag == 1'b1, "R7 flag sticky", int'(flag), 1);
    clear();
    check(flag == 1'b0, "R7 clear drops flag", int'(flag), 0);
    check(irq == 1'b1, "R9 irq still high one cycle", int'(irq), 1);
    tick();
    check(irq == 1'b0, "R9 irq drops after clear", int'(irq), 0);

    conv(0, 'hFFF);
    check(flag == 1'b1, "R2 R10 above hi sets flag", int'(flag), 1);
    clear();

    // R5: illegal select dropped, channel 0 still guarded
    wr_sel(20);
    conv(0, 'hFFF);
    check(flag == 1'b1, "R5 illegal select dropped", int'(flag), 1);
    clear();
    wr_sel(17);
    conv(17, 'h000);
    check(flag == 1'b1, "R5 channel 17 guarded", int'(flag), 1);
    clear();
    conv(0, 'h000);
    check(flag == 1'b0, "R6 old channel unguarded", int'(flag), 0);

    // R8: set and clear in same cycle
    conv(17, 'hFFF);
    clr = 1'b1; valid = 1'b1; chan = 5'd17; data = 12'hFFF;
    tick();
    clr = 1'b0; valid = 1'b0;
    check(flag == 1'b1, "R8 set wins over clear", int'(flag), 1);
    clear();
    check(flag == 1'b0, "R7 clear after R8", int'(flag), 0);

    // R9: enable gate
    wr_ien(1'b0);
    conv(17, 'h000);
    tick();
    check(irq == 1'b0, "R9 irq gated by enable", int'(irq), 0);
    clear();

    // R10: unsigned compare around mid-scale
    wr_lo('h0800);
    wr_hi('h0FFF);
    conv(17, 'h7FF);
    check(flag == 1'b1, "R10 0x7FF below 0x800", int'(flag), 1);
    clear();
    conv(17, 'h800);
    check(flag == 1'b0, "R3 R10 0x800 inside", int'(flag), 0);
    conv(17, 'hFFF);
    check(flag == 1'b0, "R10 0xFFF equals hi", int'(flag), 0);

    repeat (3) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule